// File: doc/BRIEF.md
# Key-Guarded Board Control Register File

This block is a small register file on a 32-bit register bus for board-level housekeeping. It returns a fixed board identity word, holds the LED pattern, two configuration words, and two flag words. One flag word is volatile and one is non-volatile. Each flag word has its own set address and its own clear address. Some legacy offsets return fixed values. All unmapped offsets read zero and drop writes.

A reset-control register sits behind a 16-bit key register. Software first writes the key, then writes reset control. If that write has the request bit set, the block emits a one-cycle board-reset pulse. The pulse wipes the volatile flags and leaves the non-volatile flags alone. Only the power-on reset input clears the non-volatile flags.

Reads are combinational from `addr`. Writes take effect at the rising clock edge where `wr_en` is high.

Top module: `sysctl_regs`

## Requirements
- R1: Reading offset 0x00 returns the constant 0x41007004.
- R2: Offset 0x08 is a read/write LED register. Its low LED_W bits (8 by default) drive `led_out` and read back at 0x08. The upper read bits are zero.
- R3: Offset 0x20 holds the key. Writing exactly 0x0000A05F stores 0xA05F. Any other write stores bits 14:0 of the data with bit 15 cleared. The register reads back zero-extended.
- R4: A write to reset control at offset 0x40 is stored only while the key register holds 0xA05F. Otherwise the write is dropped. The stored word reads back at 0x40 and drives `rst_level`.
- R5: An accepted reset-control write with data bit 8 set drives `board_rst_pulse` high for exactly the one cycle after the write edge. No other write raises it.
- R6: Volatile flags read at 0x30. Writing ones to 0x30 sets bits and writing ones to 0x34 clears bits. Non-volatile flags work the same way, reading and setting at 0x38 and clearing at 0x3C.
- R7: In a cycle where `board_rst_pulse` is high, the volatile flags are cleared at the closing edge. This overrides a set write in that same cycle. The non-volatile flags are unchanged.
- R8: Offsets 0x28 and 0x2C are plain 32-bit read/write configuration words.
- R9: Offset 0x44 reads 0x1, offset 0x50 reads 0x1000, and every other unlisted offset reads zero. Writes to these offsets change no register.
- R10: While `rst_n` is low, the LED, key, configuration, both flag and reset-control registers are cleared, and `board_rst_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Combinational read data for `addr` |
| led_out | output | LED_W (8) | LED drive lines |
| board_rst_pulse | output | 1 | One-cycle board-reset request |
| rst_level | output | DATA_W (32) | Stored reset-control word |

## Verification
The board-reset pulse and a flag-set write can land in the same cycle. The bench provokes this by issuing a flag-set write right after an accepted reset request, while the pulse is high. It then checks that the volatile flags read zero, that the non-volatile flags are untouched, and that a later identical set write takes effect normally. A second concern is a reset-control write while the key is not held. The bench checks that both the stored word and the pulse stay unchanged after such a write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned OFF_ID      = 'h00;
   localparam int unsigned OFF_LED     = 'h08;
   localparam int unsigned OFF_KEY     = 'h20;
   localparam int unsigned OFF_CFG_A   = 'h28;
   localparam int unsigned OFF_CFG_B   = 'h2C;
   localparam int unsigned OFF_VFLAG   = 'h30;
   localparam int unsigned OFF_VFLAG_C = 'h34;
   localparam int unsigned OFF_NVFLAG  = 'h38;
   localparam int unsigned OFF_NVFLG_C = 'h3C;
   localparam int unsigned OFF_RSTCTL  = 'h40;
   localparam int unsigned OFF_BUSCTL  = 'h44;
   localparam int unsigned OFF_DISPCTL = 'h50;

   localparam logic [31:0] BUSCTL_VAL  = 32'h0000_0001;
   localparam logic [31:0] DISPCTL_VAL = 32'h0000_1000;
endpackage

// File: rtl/sysctl_plain_reg.sv
module sysctl_plain_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   // R8: without a write strobe the register keeps its value
   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/sysctl_setclr_reg.sv
module sysctl_setclr_reg #(
   parameter int unsigned W        = 32,
   parameter bit          VOLATILE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits,
   input  logic         board_clr,
   output logic [W-1:0] q
);
   logic wipe;

   generate
      if (VOLATILE) begin : g_vol
         assign wipe = board_clr;
      end else begin : g_nonvol
         assign wipe = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wipe)   q <= '0;
      else if (clr_en) q <= q & ~bits;
      else if (set_en) q <= q | bits;
   end

   // R6: every bit written at the set address is on afterwards
   a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en && !wipe) |=> ((q & $past(bits)) == $past(bits)));

   // R6: every bit written at the clear address is off afterwards
   a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((q & $past(bits)) == '0));

   generate
      if (VOLATILE) begin : g_chk_vol
         // R7: board reset empties the volatile word
         a_r7_board_wipe: assert property (@(posedge clk) disable iff (!rst_n)
            board_clr |=> (q == '0));
      end else begin : g_chk_nv
         // R7: board reset alone leaves the non-volatile word intact
         a_r7_nv_survives: assert property (@(posedge clk) disable iff (!rst_n)
            (board_clr && !set_en && !clr_en) |=> $stable(q));
      end
   endgenerate
endmodule

// File: rtl/sysctl_lock_gate.sv
module sysctl_lock_gate #(
   parameter int unsigned         DATA_W = 32,
   parameter int unsigned         KEY_W  = 16,
   parameter logic [KEY_W-1:0]    KEY    = 16'hA05F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [KEY_W-1:0]  key_q,
   output logic              open
);
   localparam logic [DATA_W-1:0] KEY_WIDE = DATA_W'(KEY);

   generate
      if (KEY_W > DATA_W) begin : g_bad_key_w
         $error("sysctl_lock_gate: KEY_W exceeds DATA_W");
      end
      if (!KEY[KEY_W-1]) begin : g_bad_key
         $error("sysctl_lock_gate: key must have its top bit set");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         key_q <= '0;
      else if (we) begin
         if (wdata == KEY_WIDE) key_q <= KEY;
         else                   key_q <= {1'b0, wdata[KEY_W-2:0]};
      end
   end

   assign open = (key_q == KEY);

   // R3: writing the exact key opens the gate on the next cycle
   a_r3_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == KEY_WIDE) |=> open);

   // R3: any other write leaves the gate shut
   a_r3_other_shuts: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata != KEY_WIDE) |=> !open);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int unsigned         DATA_W   = 32,
   parameter int unsigned         ADDR_W   = 8,
   parameter int unsigned         LED_W    = 8,
   parameter int unsigned         KEY_W    = 16,
   parameter logic [KEY_W-1:0]    KEY      = 16'hA05F,
   parameter int unsigned         RST_BIT  = 8,
   parameter logic [DATA_W-1:0]   ID_VALUE = 32'h4100_7004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [LED_W-1:0]  led_out,
   output logic              board_rst_pulse,
   output logic [DATA_W-1:0] rst_level
);
   generate
      if (DATA_W < 32)       begin : g_bad_dw  $error("sysctl_regs: DATA_W below 32");  end
      if (ADDR_W < 7)        begin : g_bad_aw  $error("sysctl_regs: ADDR_W below 7");   end
      if (LED_W > DATA_W)    begin : g_bad_led $error("sysctl_regs: LED_W too wide");   end
      if (RST_BIT >= DATA_W) begin : g_bad_rb  $error("sysctl_regs: RST_BIT out of range"); end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
      return a == ADDR_W'(off);
   endfunction

   logic              we_led, we_key, we_cfg_a, we_cfg_b, we_rst;
   logic              set_v, clr_v, set_nv, clr_nv;
   logic              key_open;
   logic [KEY_W-1:0]  key_q;
   logic [LED_W-1:0]  led_q;
   logic [DATA_W-1:0] cfg_a_q, cfg_b_q, vflag_q, nvflag_q, rst_q;
   logic              rst_accept;

   assign we_led   = wr_en && hit(addr, OFF_LED);
   assign we_key   = wr_en && hit(addr, OFF_KEY);
   assign we_cfg_a = wr_en && hit(addr, OFF_CFG_A);
   assign we_cfg_b = wr_en && hit(addr, OFF_CFG_B);
   assign set_v    = wr_en && hit(addr, OFF_VFLAG);
   assign clr_v    = wr_en && hit(addr, OFF_VFLAG_C);
   assign set_nv   = wr_en && hit(addr, OFF_NVFLAG);
   assign clr_nv   = wr_en && hit(addr, OFF_NVFLG_C);
   assign we_rst   = wr_en && hit(addr, OFF_RSTCTL) && key_open;

   sysctl_lock_gate #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_lock (
      .clk(clk), .rst_n(rst_n), .we(we_key), .wdata(wdata),
      .key_q(key_q), .open(key_open));

   sysctl_plain_reg #(.W(LED_W)) u_led (
      .clk(clk), .rst_n(rst_n), .we(we_led), .d(wdata[LED_W-1:0]), .q(led_q));
   sysctl_plain_reg #(.W(DATA_W)) u_cfg_a (
      .clk(clk), .rst_n(rst_n), .we(we_cfg_a), .d(wdata), .q(cfg_a_q));
   sysctl_plain_reg #(.W(DATA_W)) u_cfg_b (
      .clk(clk), .rst_n(rst_n), .we(we_cfg_b), .d(wdata), .q(cfg_b_q));
   sysctl_plain_reg #(.W(DATA_W)) u_rstctl (
      .clk(clk), .rst_n(rst_n), .we(we_rst), .d(wdata), .q(rst_q));

   sysctl_setclr_reg #(.W(DATA_W), .VOLATILE(1'b1)) u_vflag (
      .clk(clk), .rst_n(rst_n), .set_en(set_v), .clr_en(clr_v), .bits(wdata),
      .board_clr(board_rst_pulse), .q(vflag_q));
   sysctl_setclr_reg #(.W(DATA_W), .VOLATILE(1'b0)) u_nvflag (
      .clk(clk), .rst_n(rst_n), .set_en(set_nv), .clr_en(clr_nv), .bits(wdata),
      .board_clr(board_rst_pulse), .q(nvflag_q));

   assign rst_accept = we_rst && wdata[RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) board_rst_pulse <= 1'b0;
      else        board_rst_pulse <= rst_accept;
   end

   assign led_out   = led_q;
   assign rst_level = rst_q;

   always_comb begin
      rd_data = '0;
      unique case (1'b1)
         hit(addr, OFF_ID):      rd_data = ID_VALUE;
         hit(addr, OFF_LED):     rd_data = DATA_W'(led_q);
         hit(addr, OFF_KEY):     rd_data = DATA_W'(key_q);
         hit(addr, OFF_CFG_A):   rd_data = cfg_a_q;
         hit(addr, OFF_CFG_B):   rd_data = cfg_b_q;
         hit(addr, OFF_VFLAG):   rd_data = vflag_q;
         hit(addr, OFF_NVFLAG):  rd_data = nvflag_q;
         hit(addr, OFF_RSTCTL):  rd_data = rst_q;
         hit(addr, OFF_BUSCTL):  rd_data = DATA_W'(BUSCTL_VAL);
         hit(addr, OFF_DISPCTL): rd_data = DATA_W'(DISPCTL_VAL);
         default:                rd_data = '0;
      endcase
   end

   // R4: a reset-control write without the key changes nothing
   a_r4_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit(addr, OFF_RSTCTL) && !key_open) |=> $stable(rst_level));

   // R5: the pulse has a cause in the previous cycle
   a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      board_rst_pulse |-> $past(wr_en && hit(addr, OFF_RSTCTL) && key_open && wdata[RST_BIT]));

   // R1: the identity word never changes
   a_r1_id_const: assert property (@(posedge clk) disable iff (!rst_n)
      hit(addr, OFF_ID) |-> (rd_data == ID_VALUE));

   // R2: the LED lines follow a LED write
   a_r2_led_follow: assert property (@(posedge clk) disable iff (!rst_n)
      we_led |=> (led_out == $past(wdata[LED_W-1:0])));
endmodule

// File: tb/sysctl_regs_test.sv
`timescale 1ns/100ps
module sysctl_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic [7:0]  led_out;
   logic        board_rst_pulse;
   logic [31:0] rst_level;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sysctl_regs uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_data(rd_data), .led_out(led_out), .board_rst_pulse(board_rst_pulse),
      .rst_level(rst_level));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic check_cleared(input string tag);
      rd_chk(tag, 8'h08, 0); rd_chk(tag, 8'h20, 0); rd_chk(tag, 8'h28, 0);
      rd_chk(tag, 8'h2C, 0); rd_chk(tag, 8'h30, 0); rd_chk(tag, 8'h38, 0);
      rd_chk(tag, 8'h40, 0);
      chk(tag, {24'h0, led_out}, 0);
      chk(tag, {31'h0, board_rst_pulse}, 0);
      chk(tag, rst_level, 0);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_v, exp_nv;
      repeat (3) @(negedge clk);
      check_cleared("R10 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_cleared("R10 after reset");

      // R1 identity and R9 constants
      rd_chk("R1 id", 8'h00, 32'h4100_7004);
      rd_chk("R9 busctl", 8'h44, 32'h1);
      rd_chk("R9 dispctl", 8'h50, 32'h1000);

      // R2 LED walk
      for (int i = 0; i < 8; i++) begin
         wr(8'h08, 32'h1 << i);
         chk("R2 led lines", {24'h0, led_out}, 32'h1 << i);
         rd_chk("R2 led read", 8'h08, 32'h1 << i);
      end
      wr(8'h08, 32'hFFFF_FF5A);
      rd_chk("R2 led upper zero", 8'h08, 32'h5A);

      // R8 configuration words
      for (int i = 0; i < 4; i++) begin
         wr(8'h28, 32'h1357_9BDF ^ (32'h1 << (i * 7)));
         wr(8'h2C, ~(32'h2468_ACE0 + i));
         rd_chk("R8 cfg a", 8'h28, 32'h1357_9BDF ^ (32'h1 << (i * 7)));
         rd_chk("R8 cfg b", 8'h2C, ~(32'h2468_ACE0 + i));
      end

      // R6 flag sweep with a bench model
      exp_v = 0; exp_nv = 0;
      for (int i = 0; i < 32; i++) begin
         wr(8'h30, 32'h1 << i);        exp_v  |= 32'h1 << i;
         wr(8'h38, 32'h1 << (31 - i)); exp_nv |= 32'h1 << (31 - i);
         if (i % 5 == 4) begin
            wr(8'h34, 32'h0F0F_0F0F); exp_v  &= ~32'h0F0F_0F0F;
            wr(8'h3C, 32'h3333_3333); exp_nv &= ~32'h3333_3333;
         end
         rd_chk("R6 vflag", 8'h30, exp_v);
         rd_chk("R6 nvflag", 8'h38, exp_nv);
      end

      // R3 key register
      wr(8'h20, 32'h1234);      rd_chk("R3 plain", 8'h20, 32'h1234);
      wr(8'h20, 32'hFFFF);      rd_chk("R3 bit15 cleared", 8'h20, 32'h7FFF);
      wr(8'h20, 32'h0001_A05F); rd_chk("R3 wide not key", 8'h20, 32'h205F);

      // R4 locked write dropped
      wr(8'h40, 32'h155);
      rd_chk("R4 locked", 8'h40, 0);
      chk("R5 no pulse locked", {31'h0, board_rst_pulse}, 0);
      wr(8'h20, 32'hA05F);      rd_chk("R3 key", 8'h20, 32'hA05F);
      wr(8'h40, 32'h55);
      rd_chk("R4 accepted", 8'h40, 32'h55);
      chk("R4 level", rst_level, 32'h55);
      chk("R5 no pulse bit8 low", {31'h0, board_rst_pulse}, 0);

      // R5/R7 pulse collides with a volatile set write
      wr(8'h30, 32'hF0F0);      wr(8'h34, ~32'hF0F0);
      wr(8'h38, 32'h0FF0);      wr(8'h3C, ~32'h0FF0);
      wr(8'h40, 32'h100);
      chk("R5 pulse high", {31'h0, board_rst_pulse}, 1);
      wr(8'h30, 32'h3);
      chk("R5 pulse one cycle", {31'h0, board_rst_pulse}, 0);
      rd_chk("R7 vflag wiped", 8'h30, 0);
      rd_chk("R7 nvflag kept", 8'h38, 32'h0FF0);
      wr(8'h30, 32'h3);
      rd_chk("R7 set after pulse", 8'h30, 32'h3);

      // R4 relock then write with bit 8
      wr(8'h20, 32'h0);
      wr(8'h40, 32'h1FF);
      chk("R5 no pulse relocked", {31'h0, board_rst_pulse}, 0);
      rd_chk("R4 relocked", 8'h40, 32'h100);

      // R9 writes to constant or unmapped offsets
      wr(8'h00, '1); wr(8'h44, '1); wr(8'h50, '1); wr(8'h04, '1);
      wr(8'h0C, '1); wr(8'h24, '1); wr(8'h4C, '1); wr(8'h31, '1);
      rd_chk("R9 id kept", 8'h00, 32'h4100_7004);
      rd_chk("R9 busctl kept", 8'h44, 32'h1);
      rd_chk("R9 dispctl kept", 8'h50, 32'h1000);
      rd_chk("R9 unmapped 04", 8'h04, 0);
      rd_chk("R9 unmapped 24", 8'h24, 0);
      rd_chk("R9 unmapped 34", 8'h34, 0);
      rd_chk("R9 led untouched", 8'h08, 32'h5A);
      rd_chk("R9 vflag untouched", 8'h30, 32'h3);
      rd_chk("R9 cfg untouched", 8'h28, 32'h1357_9BDF ^ (32'h1 << 21));

      // R10 power-on reset mid-run clears non-volatile flags too
      rst_n = 1'b0;
      @(negedge clk);
      check_cleared("R10 por");
      rst_n = 1'b1;
      @(negedge clk);
      check_cleared("R10 por released");

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule